// File: doc/BRIEF.md
# Tri-State PWM Input Supervisor

This block sits between a three-level PWM input and the gate sequencer of a synchronous buck power stage. Two comparator bits describe the input. One says the level is above the high threshold. The other says it is below the low threshold. The block turns them into a clean PWM command. When the input rests between the two thresholds for longer than a hold-off time, the block treats the driving controller as tri-stated. It then asks the sequencer to turn both switches off.

While the input is tri-stated and the supply is good, the block also watches a switch-node overvoltage comparator. If that comparator trips, it latches a request to hold the low-side switch on, so that the load is clamped. The tri-state condition and the latch are released together, and only when the input drives to logic low. After that release, the PWM command again controls the switches. Until supply-good is asserted, every switch is held off and the input is not decoded.

Top module: `pwm_tristate_supervisor`

## Requirements
- R1: Input decode: `above_hi_i=1, below_lo_i=0` is HIGH and `above_hi_i=0, below_lo_i=1` is LOW. Both bits clear, or both bits set, is MID. One cycle after a HIGH sample, `pwm_cmd_o` is 1. One cycle after a LOW sample, `pwm_cmd_o` is 0.
- R2: While `rst_ni` is low, `force_off_o=1`, `pwm_cmd_o=0` and `force_ls_o=0`. The block leaves reset in the tri-state condition.
- R3: While `supply_good_i=0`, from the next cycle on, the outputs are `force_off_o=1`, `pwm_cmd_o=0` and `force_ls_o=0`. This holds whatever the input or overvoltage comparator show.
- R4: A MID run of fewer than `HOLD_CYCLES` consecutive samples leaves `pwm_cmd_o` at its last HIGH/LOW value and keeps `force_off_o=0`.
- R5: After `HOLD_CYCLES` consecutive MID samples with supply good, the tri-state condition is entered. From the following cycle, `force_off_o=1` and `pwm_cmd_o=0`.
- R6: The tri-state condition ends only on a LOW sample. HIGH or MID samples keep it, and `pwm_cmd_o` stays 0. After the exit, HIGH samples again drive `pwm_cmd_o`.
- R7: `ov_i` is ignored outside the tri-state condition and while supply-good is low. In those cases `force_ls_o` stays 0.
- R8: In the tri-state condition with supply good, `ov_i=1` sets `force_ls_o=1` from the next cycle. The request stays set after `ov_i` drops and through HIGH or MID samples. While it is set, `force_off_o=0` and `pwm_cmd_o=0`, because low-side-on takes priority.
- R9: The LOW sample that ends the tri-state condition also clears `force_ls_o`.
- R10: When `supply_good_i` falls, the tri-state condition is re-entered and any latched low-side request is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_good_i | input | 1 | Supply above its undervoltage threshold |
| above_hi_i | input | 1 | Input is above the high threshold |
| below_lo_i | input | 1 | Input is below the low threshold |
| ov_i | input | 1 | Switch node is above the overvoltage warning level |
| pwm_cmd_o | output | 1 | Clean PWM command to the gate sequencer |
| force_off_o | output | 1 | Turn both switches off |
| force_ls_o | output | 1 | Hold the low-side switch on; overrides force_off_o |

## Verification
The bench runs a MID run exactly one sample shorter than the hold-off, and then one sample longer. A counter that is off by one would either blank the PWM command too early or never reach the tri-state condition. It drives HIGH straight out of the tri-state condition, and it trips the overvoltage comparator both before and after arming. A design that released on any valid level, or armed the latch too early, would show a spurious PWM pulse or a low-side request during normal switching. It also drops supply-good while the latch is set and drives both comparator bits at once. A design that kept the latch without supply, or decoded the illegal code as a level, would show a changed output there.

// File: rtl/pts_pkg.sv
package pts_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_MID  = 2'd2
  } pts_lvl_e;
endpackage

// File: rtl/pts_level_decode.sv
module pts_level_decode
  import pts_pkg::*;
(
  input  logic     above_hi_i,
  input  logic     below_lo_i,
  output pts_lvl_e lvl_o
);
  // both bits set cannot be a valid level: treat as mid-window
  always_comb begin
    unique case ({above_hi_i, below_lo_i})
      2'b10:   lvl_o = LVL_HIGH;
      2'b01:   lvl_o = LVL_LOW;
      default: lvl_o = LVL_MID;
    endcase
  end
endmodule

// File: rtl/pts_hiz_detect.sv
module pts_hiz_detect
  import pts_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     supply_good_i,
  input  pts_lvl_e lvl_i,
  output logic     hiz_o,
  output logic     hiz_set_o
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] mid_cnt_q;
  logic          hiz_q;
  logic          is_mid;

  assign is_mid    = (lvl_i == LVL_MID);
  assign hiz_set_o = supply_good_i && !hiz_q && is_mid && (mid_cnt_q == LAST);
  assign hiz_o     = hiz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_cnt_q <= '0;
    end else if (!supply_good_i || !is_mid || hiz_q) begin
      mid_cnt_q <= '0;
    end else if (mid_cnt_q != LAST) begin
      mid_cnt_q <= mid_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hiz_q <= 1'b1;
    end else if (!supply_good_i) begin
      hiz_q <= 1'b1;
    end else if (hiz_q) begin
      hiz_q <= (lvl_i != LVL_LOW);
    end else if (hiz_set_o) begin
      hiz_q <= 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_cnt_q <= LAST); // R5
  AST_HIZ_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hiz_q) |-> (!$past(supply_good_i) || $past(mid_cnt_q) == LAST)); // R5
  AST_HIZ_EXIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hiz_q) |-> $past(lvl_i) == LVL_LOW); // R6
endmodule

// File: rtl/pts_ov_latch.sv
module pts_ov_latch
  import pts_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     supply_good_i,
  input  logic     hiz_i,
  input  pts_lvl_e lvl_i,
  input  logic     ov_i,
  output logic     ls_req_o
);
  logic ov_q;
  logic armed;

  assign armed    = supply_good_i && hiz_i;
  assign ls_req_o = ov_q && supply_good_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_q <= 1'b0;
    end else if (!armed || lvl_i == LVL_LOW) begin
      ov_q <= 1'b0; // exit from hi-z (or no supply) clears the latch
    end else if (ov_i) begin
      ov_q <= 1'b1;
    end
  end

  AST_OV_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ov_q) |-> ($past(hiz_i) && $past(supply_good_i))); // R7
  AST_OV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_q && armed && lvl_i != LVL_LOW) |=> ov_q); // R8
  AST_OV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hiz_i && lvl_i == LVL_LOW) |=> !ov_q); // R9
endmodule

// File: rtl/pwm_tristate_supervisor.sv
module pwm_tristate_supervisor
  import pts_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_good_i,
  input  logic above_hi_i,
  input  logic below_lo_i,
  input  logic ov_i,
  output logic pwm_cmd_o,
  output logic force_off_o,
  output logic force_ls_o
);
  pts_lvl_e lvl;
  logic     hiz;
  logic     hiz_set;
  logic     ls_req;
  logic     pwm_q;

  pts_level_decode u_dec (
    .above_hi_i (above_hi_i),
    .below_lo_i (below_lo_i),
    .lvl_o      (lvl)
  );

  pts_hiz_detect #(.HOLD_CYCLES(HOLD_CYCLES)) u_hiz (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .supply_good_i (supply_good_i),
    .lvl_i         (lvl),
    .hiz_o         (hiz),
    .hiz_set_o     (hiz_set)
  );

  pts_ov_latch u_ov (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .supply_good_i (supply_good_i),
    .hiz_i         (hiz),
    .lvl_i         (lvl),
    .ov_i          (ov_i),
    .ls_req_o      (ls_req)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= 1'b0;
    end else if (!supply_good_i || hiz || hiz_set) begin
      pwm_q <= 1'b0;
    end else if (lvl == LVL_HIGH) begin
      pwm_q <= 1'b1;
    end else if (lvl == LVL_LOW) begin
      pwm_q <= 1'b0;
    end
  end

  assign pwm_cmd_o   = pwm_q;
  assign force_ls_o  = ls_req;
  assign force_off_o = (hiz || !supply_good_i) && !ls_req;

  AST_LS_NO_PWM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_ls_o |-> !pwm_cmd_o); // R8
  AST_NO_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_good_i |=> (!pwm_cmd_o && !force_ls_o)); // R3
  AST_HIZ_NO_PWM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiz |-> !pwm_cmd_o); // R6
endmodule

// File: tb/pwm_tristate_supervisor_tb_top.sv
`timescale 1ns/1ps
module pwm_tristate_supervisor_tb_top;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sg = 1'b0, hi = 1'b0, lo = 1'b0, ov = 1'b0;
  logic pwm, foff, fls;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_tristate_supervisor #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .supply_good_i(sg),
    .above_hi_i(hi), .below_lo_i(lo), .ov_i(ov),
    .pwm_cmd_o(pwm), .force_off_o(foff), .force_ls_o(fls)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(logic h, logic l);
    hi = h; lo = l;
  endtask

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s {pwm,off,ls} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R2 reset", {pwm, foff, fls}, 3'b010);
    rst_n = 1'b1; step(2);
    chk("R3 no supply", {pwm, foff, fls}, 3'b010);
    drive(1, 0); ov = 1; step(2);
    chk("R3 input and ov ignored", {pwm, foff, fls}, 3'b010);
    ov = 0; sg = 1; drive(0, 0); step(2);
    chk("R2 starts in hi-z", {pwm, foff, fls}, 3'b010);
    drive(0, 1); step(1);
    chk("R6 low releases hi-z", {pwm, foff, fls}, 3'b000);
  endtask

  task automatic t_decode;
    drive(1, 0); step(1);
    chk("R1 high", {pwm, foff, fls}, 3'b100);
    drive(0, 1); step(1);
    chk("R1 low", {pwm, foff, fls}, 3'b000);
    drive(1, 0); step(1);
    drive(1, 1); step(2);
    chk("R1 both set is mid", {pwm, foff, fls}, 3'b100);
    drive(1, 0); step(1);
  endtask

  task automatic t_short_mid;
    drive(0, 0); step(HOLD - 1);
    chk("R4 short mid holds high", {pwm, foff, fls}, 3'b100);
    drive(1, 0); step(1);
    drive(0, 0); step(HOLD - 1);
    chk("R4 counter restarts", {pwm, foff, fls}, 3'b100);
    drive(0, 1); step(1);
    drive(0, 0); step(HOLD - 1);
    chk("R4 short mid holds low", {pwm, foff, fls}, 3'b000);
    drive(1, 0); step(1);
  endtask

  task automatic t_hiz_entry;
    drive(0, 0); step(HOLD - 1);
    chk("R5 not yet hi-z", {pwm, foff, fls}, 3'b100);
    step(1);
    chk("R5 hi-z after hold-off", {pwm, foff, fls}, 3'b010);
  endtask

  task automatic t_hiz_exit;
    drive(1, 0); step(3);
    chk("R6 high does not release", {pwm, foff, fls}, 3'b010);
    drive(0, 1); step(1);
    chk("R6 low releases", {pwm, foff, fls}, 3'b000);
    drive(1, 0); step(1);
    chk("R6 pwm follows after exit", {pwm, foff, fls}, 3'b100);
  endtask

  task automatic t_ov_unarmed;
    ov = 1; step(2);
    chk("R7 ov ignored when switching", {pwm, foff, fls}, 3'b100);
    drive(0, 1); step(2);
    chk("R7 ov ignored at low", {pwm, foff, fls}, 3'b000);
    ov = 0;
  endtask

  task automatic t_ov_latch;
    drive(0, 0); step(HOLD);
    chk("R5 re-enter hi-z", {pwm, foff, fls}, 3'b010);
    ov = 1; step(1);
    chk("R8 ov latches low-side", {pwm, foff, fls}, 3'b001);
    ov = 0; step(2);
    chk("R8 latch holds after ov drops", {pwm, foff, fls}, 3'b001);
    drive(1, 0); step(2);
    chk("R8 high keeps latch", {pwm, foff, fls}, 3'b001);
    drive(0, 1); step(1);
    chk("R9 low clears latch", {pwm, foff, fls}, 3'b000);
  endtask

  task automatic t_supply;
    drive(1, 0); step(1);
    sg = 0; step(1);
    chk("R10 supply loss forces off", {pwm, foff, fls}, 3'b010);
    sg = 1; drive(0, 0); step(1);
    ov = 1; step(1);
    chk("R10 latch armed again", {pwm, foff, fls}, 3'b001);
    ov = 0; sg = 0; step(1);
    chk("R10 supply loss clears latch", {pwm, foff, fls}, 3'b010);
    sg = 1; drive(1, 0); step(2);
    chk("R10 hi-z kept after supply return", {pwm, foff, fls}, 3'b010);
  endtask

  initial begin
    step(1);
    t_reset();
    t_decode();
    t_short_mid();
    t_hiz_entry();
    t_hiz_exit();
    t_ov_unarmed();
    t_ov_latch();
    t_supply();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule